// File: doc/BRIEF.md
# Single-Operand Shift and Rotate Unit

This unit runs one single-operand operation per start strobe on a byte or on a 16-bit index value. It covers negate, complement, logical and arithmetic right shift, left shift, rotates through carry in both directions, increment, decrement, half swap, clear and test. It also runs two word rotates that treat the index value and the accumulator as one 24-bit quantity and move it by one byte. The caller supplies the operation code, a width select, the operand, the accumulator value and the current carry. One clock later the unit presents the result, the new accumulator value and the N, Z and C flags.

Each operation sets the flags in its own way. Some take the carry from the shifted-out bit. Others pass the incoming carry through untouched. An unassigned operation code leaves every registered output as it was and raises an illegal flag for that cycle. Memory access and address generation belong to the surrounding pipeline.

Top module: `shrot_unit`

## Requirements
- R1: `valid` is high in exactly the cycle after each cycle with `start` high, and low otherwise; all outputs are registered.
- R2: Operation codes: 0 negate, 1 complement, 2 logical shift right, 3 arithmetic shift right, 4 shift left, 5 rotate right through carry, 6 rotate left through carry, 7 increment, 8 decrement, 9 half swap, 10 clear, 11 test, 12 word rotate right, 13 word rotate left, 14 and 15 unassigned. With `wide`=0 codes 0 to 11 use `opnd[7:0]` and give `result[15:8]`=0. With `wide`=1 they use all 16 bits.
- R3: Negate gives the two's complement with C = (operand != 0). Complement gives the bitwise inverse with C = 1.
- R4: Logical shift right fills the top bit with 0. Arithmetic shift right keeps the top bit. Both load C from the old bit 0.
- R5: Shift left fills bit 0 with 0. Rotate left fills bit 0 with `c_in`. Both load C from the old top bit. Rotate right fills the top bit with `c_in` and loads C from the old bit 0.
- R6: Increment and decrement wrap within the selected width, and C equals `c_in`.
- R7: Half swap exchanges the two 4-bit halves of a byte, or the two bytes of a 16-bit value. C equals `c_in`.
- R8: Clear gives 0 with N=0 and Z=1. Test gives the operand unchanged. Both give C equal to `c_in`.
- R9: Word rotate right gives result = {acc_in, opnd[15:8]} and acc_out = opnd[7:0]. Word rotate left gives result = {opnd[7:0], acc_in} and acc_out = opnd[15:8]. Both are always 16-bit, take N and Z from the 16-bit result, and give C equal to `c_in`.
- R10: N equals the top bit of the result for the chosen width. Z is 1 exactly when the result is zero.
- R11: Codes 14 and 15 raise `illegal` with `valid`, and leave `result`, `acc_out` and the three flags at their previous values.
- R12: For codes 0 to 11, `acc_out` equals `acc_in`.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 selects 16-bit operation for codes 0 to 11 |
| opnd | input | 16 | Operand / index value |
| acc_in | input | 8 | Accumulator value |
| c_in | input | 1 | Incoming carry |
| valid | output | 1 | Result present this cycle |
| result | output | 16 | Operation result |
| acc_out | output | 8 | Updated accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| illegal | output | 1 | Unassigned operation seen |

## Verification
The properties assume that `start`, `op`, `wide` and the data inputs are stable across the clock edge that samples them, and that `start` is low while `rst` is high. The carry check for increment and decrement compares with the `c_in` of the launch cycle. The checks on narrow results assume `wide` is known whenever `start` is high. The bench changes every input only on falling edges and holds `start` low throughout reset. It issues operations back to back, so each check sees the launch-cycle inputs unchanged.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [3:0] {
    OP_NEG  = 4'd0,
    OP_CPL  = 4'd1,
    OP_SRL  = 4'd2,
    OP_SRA  = 4'd3,
    OP_SLL  = 4'd4,
    OP_RRC  = 4'd5,
    OP_RLC  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SWAP = 4'd9,
    OP_CLR  = 4'd10,
    OP_TNZ  = 4'd11,
    OP_WRR  = 4'd12,
    OP_WRL  = 4'd13
  } shrot_op_e;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  shrot_op_e      op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   r,
  output logic           cout,
  output logic           ok
);
  localparam int HW = W / 2;

  always_comb begin
    r    = a;
    cout = cin;
    ok   = 1'b1;
    case (op)
      OP_NEG:  begin r = (~a) + W'(1); cout = |a; end
      OP_CPL:  begin r = ~a; cout = 1'b1; end
      OP_SRL:  begin r = {1'b0, a[W-1:1]}; cout = a[0]; end
      OP_SRA:  begin r = {a[W-1], a[W-1:1]}; cout = a[0]; end
      OP_SLL:  begin r = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      OP_RRC:  begin r = {cin, a[W-1:1]}; cout = a[0]; end
      OP_RLC:  begin r = {a[W-2:0], cin}; cout = a[W-1]; end
      OP_INC:  r = a + W'(1);
      OP_DEC:  r = a - W'(1);
      OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
      OP_CLR:  r = '0;
      OP_TNZ:  r = a;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic [WW-1:0] res,
  input  logic          w16,
  output logic          n,
  output logic          z
);
  always_comb begin
    if (w16) begin
      n = res[WW-1];
      z = (res == '0);
    end else begin
      n = res[BW-1];
      z = (res[BW-1:0] == '0);
    end
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  shrot_op_e     op,
  input  logic          wide,
  input  logic [WW-1:0] x,
  input  logic [BW-1:0] acc,
  input  logic          cin,
  output logic [WW-1:0] res,
  output logic [BW-1:0] acc_nx,
  output logic          cout,
  output logic          ok,
  output logic          is_word
);
  logic [WW-1:0] lane_r [2];
  logic [1:0]    lane_c;
  logic [1:0]    lane_ok;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = BW * (g + 1);
    logic [LW-1:0] r_w;
    shrot_lane #(.W(LW)) u_lane (
      .op   (op),
      .a    (x[LW-1:0]),
      .cin  (cin),
      .r    (r_w),
      .cout (lane_c[g]),
      .ok   (lane_ok[g])
    );
    assign lane_r[g] = WW'(r_w);
  end

  always_comb begin
    is_word = 1'b0;
    acc_nx  = acc;
    cout    = cin;
    res     = lane_r[wide];
    ok      = lane_ok[wide];
    case (op)
      OP_WRR: begin
        is_word = 1'b1;
        ok      = 1'b1;
        res     = {acc, x[WW-1:BW]};
        acc_nx  = x[BW-1:0];
      end
      OP_WRL: begin
        is_word = 1'b1;
        ok      = 1'b1;
        res     = {x[BW-1:0], acc};
        acc_nx  = x[WW-1:BW];
      end
      default: cout = lane_c[wide];
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic [WW-1:0]     opnd,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic              c_in,
  output logic              valid,
  output logic [WW-1:0]     result,
  output logic [BYTE_W-1:0] acc_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              illegal
);
  shrot_op_e         op_e;
  logic [WW-1:0]     res_c;
  logic [BYTE_W-1:0] acc_c;
  logic              c_c, ok_c, word_c, n_c, z_c;

  assign op_e = shrot_op_e'(op);

  shrot_core #(.BW(BYTE_W)) u_core (
    .op      (op_e),
    .wide    (wide),
    .x       (opnd),
    .acc     (acc_in),
    .cin     (c_in),
    .res     (res_c),
    .acc_nx  (acc_c),
    .cout    (c_c),
    .ok      (ok_c),
    .is_word (word_c)
  );

  shrot_flags #(.BW(BYTE_W)) u_flags (
    .res (res_c),
    .w16 (wide | word_c),
    .n   (n_c),
    .z   (z_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
      acc_out <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      valid   <= start;
      illegal <= start & ~ok_c;
      if (start && ok_c) begin
        result  <= res_c;
        acc_out <= acc_c;
        flag_n  <= n_c;
        flag_z  <= z_c;
        flag_c  <= c_c;
      end
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WW = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [3:0]        op,
  input logic              wide,
  input logic [WW-1:0]     opnd,
  input logic [BYTE_W-1:0] acc_in,
  input logic              c_in,
  input logic              valid,
  input logic [WW-1:0]     result,
  input logic [BYTE_W-1:0] acc_out,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              illegal
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> valid); // R1
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && !wide && op < 4'd12) |=> (result[WW-1:BYTE_W] == '0)); // R2
  AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (start && (op == 4'd7 || op == 4'd8)) |=> (flag_c == $past(c_in))); // R6
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (start && op == 4'd10) |=> (result == '0 && flag_z && !flag_n)); // R8
  AST_WRR_ACC: assert property (@(posedge clk) disable iff (rst)
    (start && op == 4'd12) |=> (acc_out == $past(opnd[BYTE_W-1:0]))); // R9
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (valid && !illegal) |-> (flag_z == (result == '0))); // R10
  AST_N_NARROW: assert property (@(posedge clk) disable iff (rst)
    (start && !wide && op < 4'd12) |=> (flag_n == result[BYTE_W-1])); // R10
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(result) && $stable(acc_out) && $stable(flag_n)
                 && $stable(flag_z) && $stable(flag_c))); // R11
  AST_ACC_PASS: assert property (@(posedge clk) disable iff (rst)
    (start && op < 4'd12) |=> (acc_out == $past(acc_in))); // R12
endmodule

bind shrot_unit shrot_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op      (op),
  .wide    (wide),
  .opnd    (opnd),
  .acc_in  (acc_in),
  .c_in    (c_in),
  .valid   (valid),
  .result  (result),
  .acc_out (acc_out),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .flag_c  (flag_c),
  .illegal (illegal)
);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic [15:0] opnd = '0;
  logic [7:0]  acc_in = '0;
  logic        c_in = 1'b0;
  logic        valid, flag_n, flag_z, flag_c, illegal;
  logic [15:0] result;
  logic [7:0]  acc_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct packed {
    logic [15:0] res;
    logic [7:0]  acc;
    logic        n, z, c, ill;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  st = '0;

  always #10 clk = ~clk;

  shrot_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide(wide),
    .opnd(opnd), .acc_in(acc_in), .c_in(c_in), .valid(valid),
    .result(result), .acc_out(acc_out), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .illegal(illegal)
  );

  function automatic exp_t model(input logic [3:0] o, input logic w,
                                 input logic [15:0] xi, input logic [7:0] a,
                                 input logic ci, input exp_t prev);
    exp_t e;
    logic [15:0] x, r, mask;
    logic c;
    int msb;
    if (o >= 4'd14) begin
      e = prev;
      e.ill = 1'b1;
      return e;
    end
    mask = w ? 16'hFFFF : 16'h00FF;
    msb  = w ? 15 : 7;
    x    = xi & mask;
    c    = ci;
    e.acc = a;
    case (o)
      4'd0:  begin r = (16'd0 - x) & mask; c = (x != 0); end
      4'd1:  begin r = ~x & mask; c = 1'b1; end
      4'd2:  begin r = x >> 1; c = x[0]; end
      4'd3:  begin r = (x >> 1) | (16'(x[msb]) << msb); c = x[0]; end
      4'd4:  begin r = (x << 1) & mask; c = x[msb]; end
      4'd5:  begin r = (x >> 1) | (16'(ci) << msb); c = x[0]; end
      4'd6:  begin r = ((x << 1) | 16'(ci)) & mask; c = x[msb]; end
      4'd7:  r = (x + 16'd1) & mask;
      4'd8:  r = (x - 16'd1) & mask;
      4'd9:  r = w ? {x[7:0], x[15:8]} : {8'h00, x[3:0], x[7:4]};
      4'd10: r = 16'd0;
      4'd11: r = x;
      4'd12: begin r = {a, xi[15:8]}; e.acc = xi[7:0]; msb = 15; end
      default: begin r = {xi[7:0], a}; e.acc = xi[15:8]; msb = 15; end
    endcase
    e.res = r;
    e.n   = r[msb];
    e.z   = (r == 16'd0);
    e.c   = c;
    e.ill = 1'b0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic w, input logic [15:0] x,
                       input logic [7:0] a, input logic ci, input string tag);
    exp_t e;
    @(negedge clk);
    start  = 1'b1;
    op     = o;
    wide   = w;
    opnd   = x;
    acc_in = a;
    c_in   = ci;
    e = model(o, w, x, a, ci, st);
    st = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "valid with no pending operation");
      end else begin
        exp_t  e;
        exp_t  g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {result, acc_out, flag_n, flag_z, flag_c, illegal};
        chk(g == e, t, $sformatf(
          "got res=%h acc=%h nzc=%b%b%b ill=%b exp res=%h acc=%h nzc=%b%b%b ill=%b",
          g.res, g.acc, g.n, g.z, g.c, g.ill, e.res, e.acc, e.n, e.z, e.c, e.ill));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk({valid, result, acc_out, flag_n, flag_z, flag_c, illegal} == '0, "R13",
        $sformatf("got res=%h acc=%h v=%b exp all zero", result, acc_out, valid));

    // R1: single launch gives a one-cycle valid
    issue(4'd11, 1'b0, 16'h0042, 8'h11, 1'b0, "R8");
    idle();
    chk(valid == 1'b1, "R1", $sformatf("got valid=%b exp 1", valid));
    @(negedge clk);
    chk(valid == 1'b0, "R1", $sformatf("got valid=%b exp 0", valid));

    // Directed corners, back to back
    issue(4'd0, 1'b0, 16'h0080, 8'h00, 1'b0, "R3");  // neg 0x80
    issue(4'd0, 1'b0, 16'h0000, 8'h00, 1'b1, "R3");  // neg 0
    issue(4'd1, 1'b1, 16'h0F0F, 8'h00, 1'b0, "R3");  // cpl 16
    issue(4'd2, 1'b0, 16'hAB01, 8'h00, 1'b0, "R2");  // narrow ignores upper
    issue(4'd3, 1'b0, 16'h0081, 8'h00, 1'b0, "R4");  // sra
    issue(4'd2, 1'b1, 16'h8001, 8'h00, 1'b0, "R4");  // srl 16
    issue(4'd4, 1'b0, 16'h0081, 8'h00, 1'b0, "R5");  // sll
    issue(4'd5, 1'b0, 16'h0001, 8'h00, 1'b1, "R5");  // rrc cin=1
    issue(4'd6, 1'b1, 16'h8000, 8'h00, 1'b0, "R5");  // rlc 16 -> zero
    issue(4'd7, 1'b0, 16'h00FF, 8'h77, 1'b1, "R6");  // inc wrap, C=cin
    issue(4'd8, 1'b0, 16'h0000, 8'h77, 1'b0, "R6");  // dec wrap
    issue(4'd7, 1'b1, 16'hFFFF, 8'h77, 1'b0, "R6");  // inc 16 wrap
    issue(4'd9, 1'b0, 16'h00A5, 8'h00, 1'b1, "R7");  // nibble swap
    issue(4'd9, 1'b1, 16'h1234, 8'h00, 1'b0, "R7");  // byte swap
    issue(4'd10, 1'b1, 16'hFFFF, 8'h00, 1'b1, "R8"); // clear
    issue(4'd11, 1'b1, 16'h8000, 8'h00, 1'b0, "R8"); // test
    issue(4'd12, 1'b0, 16'h1234, 8'h56, 1'b1, "R9"); // word rot right
    issue(4'd13, 1'b0, 16'h1234, 8'h56, 1'b0, "R9"); // word rot left
    issue(4'd12, 1'b1, 16'h0000, 8'h00, 1'b0, "R9"); // word rot to zero
    issue(4'd14, 1'b0, 16'hFFFF, 8'hEE, 1'b1, "R11");
    issue(4'd15, 1'b1, 16'h5555, 8'h01, 1'b0, "R11");
    issue(4'd7, 1'b0, 16'h0010, 8'h3C, 1'b1, "R12");
    issue(4'd1, 1'b0, 16'h007F, 8'h00, 1'b0, "R10");

    // Broad sweep
    for (int i = 0; i < 300; i++) begin
      issue(4'($urandom % 16), 1'($urandom), 16'($urandom), 8'($urandom),
            1'($urandom), "R10");
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule